// File: doc/BRIEF.md
# Slot and Sample Timing Counter

This block keeps the time base of a time-slotted radio baseband. It is built from two counters. The sample counter advances once for every 48 kHz sample strobe, five strobes per data bit, and covers 256 bit periods per slot. The slot counter steps once each time the sample counter wraps, which gives 2250 slots in a one-minute frame.

After reset both counters run freely from zero. A controller brings them into step with an outside timing source through a small write port. It can load a full count directly. It can add signed corrections ("nudges") to the sample count or to the slot count. It can also arm a load that is taken on the rising edge of a pulse-per-second input. The combined count is always visible on one output word. An active-low slot pulse marks the first sample period of each slot. Three programmable equality comparators (sleep, wakeup, nudge trigger) each raise a one-cycle event when the count reaches their value.

Top module: `slot_timer_top`

## Requirements
- R1: While and directly after reset, `count_o` is 0 and all three event outputs are low. The counters then run freely from zero.
- R2: Each cycle with `samp_tick` high and no write or pulse-per-second load adds one to the sample count. A cycle with none of these leaves the count unchanged.
- R3: The sample count runs 0 to 1279. A tick at 1279 sets it to 0 and adds one to the slot count.
- R4: The slot count runs 0 to 2249. It returns to 0 when the sample count wraps while the slot count is 2249.
- R5: `slot_pulse_n` is low exactly while the sample count is 0 and is high otherwise.
- R6: `count_o` carries the slot count in bits [27:16] and the sample count in bits [10:0]. All other bits are 0.
- R7: A write to address 0 loads the count from `wr_data` in the R6 layout on that clock edge. It takes priority over a tick in the same cycle.
- R8: A write to address 1 adds the two's-complement value `wr_data[11:0]` (magnitude below 1280) to the sample count, together with any tick in the same cycle. The result wraps modulo 1280. Crossing the 1279/0 boundary adds one to or takes one from the slot count, which wraps modulo 2250.
- R9: A write to address 2 adds the two's-complement value `wr_data[12:0]` (magnitude below 2250) to the slot count modulo 2250. The sample count is unchanged when no tick is present.
- R10: A write to address 3 stores a load value in the R6 layout, with bit 31 as the enable. While the enable is 1, the clock edge that first sees `pps_in` high after a low sample loads that value. This overrides ticks, direct loads and nudges. Holding `pps_in` high loads nothing further.
- R11: Addresses 4, 5 and 6 set the sleep, wakeup and trigger compare values in the R6 layout. After reset these values are never reached. Each event output goes high for exactly one cycle when the count becomes equal to its compare value. It does not rise again until the count has left that value and come back to it.
- R12: With the address-3 enable at 0, a rising edge on `pps_in` leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_tick | input | 1 | 48 kHz sample strobe, one clock wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| pps_in | input | 1 | Pulse-per-second timing input |
| count_o | output | 32 | Combined slot and sample count |
| slot_pulse_n | output | 1 | Active-low first-sample-of-slot pulse |
| sleep_evt | output | 1 | Sleep compare event |
| wake_evt | output | 1 | Wakeup compare event |
| trig_evt | output | 1 | Nudge-trigger compare event |

## Verification
The range and wrap assertions assume that nudge magnitudes stay below one slot of samples (below 1280) and below one frame of slots (below 2250). They also assume that loaded values lie inside those ranges. The bench writes only such values. Under those assumptions one wrap correction per counter is enough. The event assertion assumes nothing about the compare values, and the bench steers the count onto them through ticks and loads. `pps_in` is driven as a slow level held across many clocks. Each load condition is therefore seen for one edge only.

// File: rtl/slt_pkg.sv
package slt_pkg;
    localparam int SAMPLES_PER_SLOT = 1280;
    localparam int SLOTS_PER_FRAME  = 2250;
    localparam int SAMP_W   = $clog2(SAMPLES_PER_SLOT);
    localparam int SLOT_W   = $clog2(SLOTS_PER_FRAME);
    localparam int WORD_W   = 32;
    localparam int SLOT_LSB = 16;
    localparam int SN_W     = 12;
    localparam int LN_W     = 13;
    localparam int DW       = 14;
    localparam int N_CMP    = 3;
    localparam int ADDR_W   = 3;
    localparam int PPS_EN_BIT = 31;

    localparam logic signed [DW-1:0] SAMP_LIM_S = DW'(SAMPLES_PER_SLOT);
    localparam logic signed [DW-1:0] SLOT_LIM_S = DW'(SLOTS_PER_FRAME);
    localparam logic signed [DW-1:0] ONE_S      = DW'(1);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [SAMP_W-1:0] samp;
    } count_t;

    typedef enum logic [ADDR_W-1:0] {
        A_LOAD   = 3'd0,
        A_SNUDGE = 3'd1,
        A_LNUDGE = 3'd2,
        A_PPS    = 3'd3,
        A_SLEEP  = 3'd4,
        A_WAKE   = 3'd5,
        A_TRIG   = 3'd6
    } reg_addr_e;

    function automatic logic [WORD_W-1:0] pack_count(count_t c);
        logic [WORD_W-1:0] r;
        r = '0;
        r[SLOT_LSB +: SLOT_W] = c.slot;
        r[SAMP_W-1:0]         = c.samp;
        return r;
    endfunction

    function automatic count_t unpack_count(logic [WORD_W-1:0] d);
        count_t c;
        c.slot = d[SLOT_LSB +: SLOT_W];
        c.samp = d[SAMP_W-1:0];
        return c;
    endfunction

    function automatic count_t advance(count_t c, logic signed [DW-1:0] sd,
                                       logic signed [DW-1:0] ld);
        logic signed [DW-1:0] s;
        logic signed [DW-1:0] l;
        logic signed [DW-1:0] cy;
        count_t r;
        s  = $signed({{(DW-SAMP_W){1'b0}}, c.samp}) + sd;
        cy = '0;
        if (s < 0) begin
            s  = s + SAMP_LIM_S;
            cy = '1;
        end else if (s >= SAMP_LIM_S) begin
            s  = s - SAMP_LIM_S;
            cy = ONE_S;
        end
        l = $signed({{(DW-SLOT_W){1'b0}}, c.slot}) + ld + cy;
        if (l < 0)
            l = l + SLOT_LIM_S;
        else if (l >= SLOT_LIM_S)
            l = l - SLOT_LIM_S;
        r.slot = l[SLOT_W-1:0];
        r.samp = s[SAMP_W-1:0];
        return r;
    endfunction
endpackage

// File: rtl/slt_regs.sv
module slt_regs
    import slt_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [WORD_W-1:0]      wr_data,
    input  logic                   pps_in,
    output logic                   load_en,
    output count_t                 load_val,
    output logic                   snudge_en,
    output logic signed [DW-1:0]   snudge,
    output logic                   lnudge_en,
    output logic signed [DW-1:0]   lnudge,
    output logic                   pps_edge,
    output count_t                 pps_val,
    output count_t [N_CMP-1:0]     cmp_val
);
    logic pps_q;
    logic pps_arm;
    reg_addr_e addr;

    assign addr      = reg_addr_e'(wr_addr);
    assign load_en   = wr_en && (addr == A_LOAD);
    assign snudge_en = wr_en && (addr == A_SNUDGE);
    assign lnudge_en = wr_en && (addr == A_LNUDGE);
    assign load_val  = unpack_count(wr_data);
    assign snudge    = {{(DW-SN_W){wr_data[SN_W-1]}}, wr_data[SN_W-1:0]};
    assign lnudge    = {{(DW-LN_W){wr_data[LN_W-1]}}, wr_data[LN_W-1:0]};
    assign pps_edge  = pps_arm && pps_in && !pps_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pps_q   <= 1'b0;
            pps_arm <= 1'b0;
            pps_val <= '0;
        end else begin
            pps_q <= pps_in;
            if (wr_en && addr == A_PPS) begin
                pps_arm <= wr_data[PPS_EN_BIT];
                pps_val <= unpack_count(wr_data);
            end
        end
    end

    for (genvar i = 0; i < N_CMP; i++) begin : g_cmp_reg
        always_ff @(posedge clk) begin
            if (rst)
                cmp_val[i] <= '1;
            else if (wr_en && wr_addr == ADDR_W'(int'(A_SLEEP) + i))
                cmp_val[i] <= unpack_count(wr_data);
        end
    end
endmodule

// File: rtl/slt_counter.sv
module slt_counter
    import slt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 load_en,
    input  count_t               load_val,
    input  logic                 snudge_en,
    input  logic signed [DW-1:0] snudge,
    input  logic                 lnudge_en,
    input  logic signed [DW-1:0] lnudge,
    input  logic                 pps_edge,
    input  count_t               pps_val,
    output count_t               cnt
);
    count_t nxt;
    logic signed [DW-1:0] sd;
    logic signed [DW-1:0] ld;
    logic plain;

    always_comb begin
        sd = (tick ? ONE_S : '0) + (snudge_en ? snudge : '0);
        ld = lnudge_en ? lnudge : '0;
        if (pps_edge)
            nxt = pps_val;
        else if (load_en)
            nxt = load_val;
        else
            nxt = advance(cnt, sd, ld);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else
            cnt <= nxt;
    end

    assign plain = !load_en && !snudge_en && !lnudge_en && !pps_edge;

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (plain && !tick) |=> $stable(cnt));

    // R3
    samp_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (plain && tick && cnt.samp == SAMP_W'(SAMPLES_PER_SLOT-1)) |=>
        (cnt.samp == '0 &&
         cnt.slot == (($past(cnt.slot) == SLOT_W'(SLOTS_PER_FRAME-1)) ?
                      '0 : $past(cnt.slot) + 1'b1)));

    // R8
    count_range_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt.samp < SAMP_W'(SAMPLES_PER_SLOT)) && (cnt.slot < SLOT_W'(SLOTS_PER_FRAME)));

    // R10
    pps_load_chk: assert property (@(posedge clk) disable iff (rst)
        pps_edge |=> (cnt == $past(pps_val)));
endmodule

// File: rtl/slt_compare.sv
module slt_compare
    import slt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  count_t cnt,
    input  count_t cmp,
    output logic   evt
);
    logic match;
    logic match_q;

    assign match = (cnt == cmp);
    assign evt   = match && !match_q;

    always_ff @(posedge clk) begin
        if (rst)
            match_q <= 1'b0;
        else
            match_q <= match;
    end

    // R11
    evt_single_chk: assert property (@(posedge clk) disable iff (rst)
        evt |=> !evt);
endmodule

// File: rtl/slot_timer_top.sv
module slot_timer_top
    import slt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              samp_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              pps_in,
    output logic [WORD_W-1:0] count_o,
    output logic              slot_pulse_n,
    output logic              sleep_evt,
    output logic              wake_evt,
    output logic              trig_evt
);
    logic                 load_en, snudge_en, lnudge_en, pps_edge;
    count_t               load_val, pps_val, cnt;
    logic signed [DW-1:0] snudge, lnudge;
    count_t [N_CMP-1:0]   cmp_val;
    logic [N_CMP-1:0]     evt;

    slt_regs i_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pps_in(pps_in), .load_en(load_en), .load_val(load_val),
        .snudge_en(snudge_en), .snudge(snudge), .lnudge_en(lnudge_en),
        .lnudge(lnudge), .pps_edge(pps_edge), .pps_val(pps_val), .cmp_val(cmp_val)
    );

    slt_counter i_counter (
        .clk(clk), .rst(rst), .tick(samp_tick), .load_en(load_en),
        .load_val(load_val), .snudge_en(snudge_en), .snudge(snudge),
        .lnudge_en(lnudge_en), .lnudge(lnudge), .pps_edge(pps_edge),
        .pps_val(pps_val), .cnt(cnt)
    );

    for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
        slt_compare i_cmp (
            .clk(clk), .rst(rst), .cnt(cnt), .cmp(cmp_val[i]), .evt(evt[i])
        );
    end

    assign count_o      = pack_count(cnt);
    assign slot_pulse_n = (cnt.samp != '0);
    assign sleep_evt    = evt[0];
    assign wake_evt     = evt[1];
    assign trig_evt     = evt[2];

    // R1
    reset_evt_chk: assert property (@(posedge clk)
        rst |=> (evt == '0 && count_o == '0));
endmodule

// File: tb/test_slot_timer_top.sv
`timescale 1ns/1ps
module test_slot_timer_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        samp_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        pps_in = 1'b0;
    logic [31:0] count_o;
    logic        slot_pulse_n, sleep_evt, wake_evt, trig_evt;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    slot_timer_top i_slot_timer_top (
        .clk(clk), .rst(rst), .samp_tick(samp_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pps_in(pps_in),
        .count_o(count_o), .slot_pulse_n(slot_pulse_n), .sleep_evt(sleep_evt),
        .wake_evt(wake_evt), .trig_evt(trig_evt)
    );

    typedef struct packed {
        logic        tick;
        logic        we;
        logic [2:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 3'd0, 32'h0000_0000, 32'h0000_0001}, // R2 tick
        '{1'b0, 1'b0, 3'd0, 32'h0000_0000, 32'h0000_0001}, // R2 hold
        '{1'b1, 1'b0, 3'd0, 32'h0000_0000, 32'h0000_0002}, // R2 tick
        '{1'b0, 1'b1, 3'd0, 32'h0005_04FF, 32'h0005_04FF}, // R7 load
        '{1'b1, 1'b0, 3'd0, 32'h0000_0000, 32'h0006_0000}, // R3 wrap, R5
        '{1'b1, 1'b0, 3'd0, 32'h0000_0000, 32'h0006_0001}, // R3
        '{1'b0, 1'b1, 3'd0, 32'h08C9_04FF, 32'h08C9_04FF}, // R7 load end of frame
        '{1'b1, 1'b0, 3'd0, 32'h0000_0000, 32'h0000_0000}, // R4 frame wrap
        '{1'b0, 1'b1, 3'd1, 32'h0000_0FFE, 32'h08C9_04FE}, // R8 borrow
        '{1'b1, 1'b1, 3'd1, 32'h0000_0003, 32'h0000_0002}, // R8 carry with tick
        '{1'b0, 1'b1, 3'd2, 32'h0000_1FFF, 32'h08C9_0002}, // R9 slot -1
        '{1'b0, 1'b1, 3'd2, 32'h0000_0005, 32'h0004_0002}, // R9 slot +5 wrap
        '{1'b1, 1'b1, 3'd0, 32'h0010_0064, 32'h0010_0064}, // R7 load beats tick
        '{1'b0, 1'b1, 3'd1, 32'h0000_0064, 32'h0010_00C8}  // R8 plain nudge
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic t, input logic we, input logic [2:0] a,
                       input logic [31:0] d, input logic p);
        @(negedge clk);
        samp_tick = t;
        wr_en     = we;
        wr_addr   = a;
        wr_data   = d;
        pps_in    = p;
        @(posedge clk);
        #1;
        samp_tick = 1'b0;
        wr_en     = 1'b0;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 count in reset", count_o, 32'h0);
        rst = 1'b0;
        @(posedge clk);
        #1;
        chk("R1 count after reset", count_o, 32'h0);
        chk("R1 events after reset", {29'd0, sleep_evt, wake_evt, trig_evt}, 32'h0);
        chk("R5 pulse low at sample 0", {31'd0, slot_pulse_n}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i].tick, VEC[i].we, VEC[i].addr, VEC[i].data, 1'b0);
            chk($sformatf("R6 vector %0d count", i), count_o, VEC[i].exp);
            chk($sformatf("R5 vector %0d pulse", i), {31'd0, slot_pulse_n},
                {31'd0, VEC[i].exp[10:0] != 11'd0});
        end

        // count now slot 16, sample 200
        cyc(1'b0, 1'b1, 3'd3, 32'h8064_0007, 1'b0);
        chk("R10 arming keeps count", count_o, 32'h0010_00C8);
        cyc(1'b1, 1'b1, 3'd1, 32'h0000_0005, 1'b1);
        chk("R10 pps load wins", count_o, 32'h0064_0007);
        cyc(1'b1, 1'b0, 3'd0, 32'h0, 1'b1);
        chk("R10 held pps no reload", count_o, 32'h0064_0008);
        cyc(1'b0, 1'b1, 3'd3, 32'h0000_0000, 1'b1);
        cyc(1'b0, 1'b0, 3'd0, 32'h0, 1'b0);
        cyc(1'b0, 1'b0, 3'd0, 32'h0, 1'b1);
        chk("R12 disabled pps ignored", count_o, 32'h0064_0008);

        cyc(1'b0, 1'b1, 3'd4, 32'h0064_000A, 1'b0);
        chk("R11 sleep idle", {31'd0, sleep_evt}, 32'h0);
        cyc(1'b1, 1'b0, 3'd0, 32'h0, 1'b0);
        chk("R11 sleep before match", {31'd0, sleep_evt}, 32'h0);
        cyc(1'b1, 1'b0, 3'd0, 32'h0, 1'b0);
        chk("R11 sleep match count", count_o, 32'h0064_000A);
        chk("R11 sleep event", {31'd0, sleep_evt}, 32'h1);
        cyc(1'b0, 1'b0, 3'd0, 32'h0, 1'b0);
        chk("R11 sleep single pulse", {31'd0, sleep_evt}, 32'h0);

        cyc(1'b0, 1'b1, 3'd6, 32'h0064_000B, 1'b0);
        cyc(1'b1, 1'b0, 3'd0, 32'h0, 1'b0);
        chk("R11 trigger event", {30'd0, trig_evt, wake_evt}, 32'h2);
        cyc(1'b1, 1'b0, 3'd0, 32'h0, 1'b0);
        chk("R11 trigger clears", {31'd0, trig_evt}, 32'h0);
        cyc(1'b0, 1'b1, 3'd0, 32'h0064_000B, 1'b0);
        chk("R11 trigger on return", {31'd0, trig_evt}, 32'h1);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule